// File: doc/BRIEF.md
# USB endpoint control and status

This block keeps the control and status state of one USB endpoint slot. A packet engine drives it with single-cycle strobes. One strobe reports a completed OUT data packet together with its byte length, one reports that an IN data packet went out, and one reports a received handshake ACK. Firmware reaches the state through a small byte-wide register port with a combinational read.

On the receive side the block latches a packet-ready bit, the byte count and an interrupt flag, and emits a one-cycle interrupt pulse. While firmware has not yet released the previous packet, any further packet is refused with a NAK indication. On the transmit side the block holds the configuration bits and the DATA0/DATA1 toggle. In normal mode the toggle advances only on an ACK that follows a transmission. In force mode it advances on every transmission. The block also maps the engine's local buffer offsets onto one shared packet buffer. When the buffer is split, IN traffic uses the upper half and OUT traffic the lower half. When it is not split, the whole buffer serves the direction that firmware selects.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset, packet-ready, the interrupt flag, every configuration bit, the byte count and the toggle are 0, and irq_o and out_nak_o are low.
- R2: A strobe on out_done_i while packet-ready is 0 makes packet-ready 1, the interrupt flag 1 and the held count equal to out_len_i on the next cycle. In that same next cycle irq_o is high for exactly one cycle.
- R3: The byte count reads low byte at address 2 and the remaining upper count bits, zero-extended, at address 3.
- R4: The status register is at address 0, with packet-ready at bit 0 and the interrupt flag at bit 1. Writing bit 0 as 0 clears packet-ready. Writing bit 0 as 1 leaves it unchanged, so only a received packet can set it.
- R5: A strobe on out_done_i while packet-ready is 1 raises out_nak_o in the same cycle, leaves the count unchanged and produces no interrupt. This holds even when firmware clears packet-ready in that cycle.
- R6: Writing 1 to status bit 1 clears the interrupt flag. A packet accepted in the same cycle as that write leaves the flag set.
- R7: The control register is at address 1 and has double-buffer enable at bit 7, isochronous at bit 6, direction at bit 5 (0 OUT, 1 IN), force-toggle at bit 3 and split at bit 2. Bits 4, 1 and 0 read 0 whatever is written.
- R8: With force-toggle 0, the toggle changes only on an ack_i that follows an in_sent_i with no ACK yet taken for it. A lone ack_i and an unacknowledged transmission leave it unchanged.
- R9: With force-toggle 1, the toggle changes on every in_sent_i, and ack_i has no effect.
- R10: With split 1, buf_in_addr_o is the IN offset with its top bit forced to 1 and buf_out_addr_o is the OUT offset with its top bit forced to 0. Both in_en_o and out_en_o are 1, whatever the direction bit holds.
- R11: With split 0, both offsets pass through unchanged, in_en_o equals the direction bit and out_en_o is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 3 | Register address |
| cpu_wdata_i | input | 8 | Register write data |
| cpu_rdata_o | output | 8 | Register read data, combinational |
| out_done_i | input | 1 | OUT data packet completed |
| out_len_i | input | CNT_W | Byte length of completed OUT packet |
| out_nak_o | output | 1 | OUT packet refused, buffer still held |
| irq_o | output | 1 | One-cycle pulse per accepted OUT packet |
| in_sent_i | input | 1 | IN data packet transmitted |
| ack_i | input | 1 | ACK handshake received |
| toggle_o | output | 1 | Current IN data toggle (0 DATA0, 1 DATA1) |
| in_addr_i | input | AW | IN-side buffer offset from the engine |
| out_addr_i | input | AW | OUT-side buffer offset from the engine |
| buf_in_addr_o | output | AW | Mapped IN buffer address |
| buf_out_addr_o | output | AW | Mapped OUT buffer address |
| in_en_o | output | 1 | IN direction owns buffer space |
| out_en_o | output | 1 | OUT direction owns buffer space |

## Verification
A packet arrival can fall in the same cycle as a firmware status write. The bench provokes this in both orders. In one case a packet is accepted while firmware writes 1 to clear the interrupt flag, and the flag must stay set. In the other case a packet arrives while packet-ready is still 1 and firmware releases the buffer in the same cycle, and the packet must be refused with the old count kept and packet-ready ending at 0. A behavioural reference model judges both cases, on every clock, alongside directed reads of the status and count registers.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam logic [2:0] REG_STAT   = 3'd0;
  localparam logic [2:0] REG_CTRL   = 3'd1;
  localparam logic [2:0] REG_CNT_LO = 3'd2;
  localparam logic [2:0] REG_CNT_HI = 3'd3;

  localparam int ST_RDY  = 0;
  localparam int ST_FLAG = 1;

  localparam int CB_DBUF  = 7;
  localparam int CB_ISO   = 6;
  localparam int CB_DIR   = 5;
  localparam int CB_FTOG  = 3;
  localparam int CB_SPLIT = 2;

  typedef struct packed {
    logic dbuf;
    logic iso;
    logic dir;
    logic ftog;
    logic split;
  } ep_cfg_t;

  function automatic logic [7:0] cfg_to_byte(ep_cfg_t c);
    logic [7:0] b;
    b = '0;
    b[CB_DBUF]  = c.dbuf;
    b[CB_ISO]   = c.iso;
    b[CB_DIR]   = c.dir;
    b[CB_FTOG]  = c.ftog;
    b[CB_SPLIT] = c.split;
    return b;
  endfunction

  function automatic ep_cfg_t byte_to_cfg(logic [7:0] b);
    ep_cfg_t c;
    c.dbuf  = b[CB_DBUF];
    c.iso   = b[CB_ISO];
    c.dir   = b[CB_DIR];
    c.ftog  = b[CB_FTOG];
    c.split = b[CB_SPLIT];
    return c;
  endfunction
endpackage

// File: rtl/usb_ep_out.sv
module usb_ep_out #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_done_i,
  input  logic [CNT_W-1:0] pkt_len_i,
  input  logic             clr_rdy_i,
  input  logic             clr_flag_i,
  output logic             rdy_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             nak_o
);
  logic             rdy_q, flag_q, irq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = pkt_done_i & ~rdy_q;
  assign nak_o  = pkt_done_i & rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      irq_q <= accept;
      if (accept)         rdy_q <= 1'b1;
      else if (clr_rdy_i) rdy_q <= 1'b0;
      // set beats clear when both land together
      if (accept)          flag_q <= 1'b1;
      else if (clr_flag_i) flag_q <= 1'b0;
      if (accept) cnt_q <= pkt_len_i;
    end
  end

  assign rdy_o  = rdy_q;
  assign flag_o = flag_q;
  assign cnt_o  = cnt_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/usb_ep_toggle.sv
module usb_ep_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sent_i,
  input  logic ack_i,
  input  logic force_i,
  output logic tog_o
);
  logic tog_q, wait_q;
  logic flip;

  assign flip = force_i ? sent_i : (ack_i & wait_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (flip) tog_q <= ~tog_q;
      if (force_i)     wait_q <= 1'b0;
      else if (sent_i) wait_q <= 1'b1;
      else if (ack_i)  wait_q <= 1'b0;
    end
  end

  assign tog_o = tog_q;
endmodule

// File: rtl/usb_ep_bufmap.sv
module usb_ep_bufmap #(
  parameter int AW = 6
) (
  input  logic          split_i,
  input  logic          dir_i,
  input  logic [AW-1:0] in_addr_i,
  input  logic [AW-1:0] out_addr_i,
  output logic [AW-1:0] buf_in_addr_o,
  output logic [AW-1:0] buf_out_addr_o,
  output logic          in_en_o,
  output logic          out_en_o
);
  localparam int HW = AW - 1;

  generate
    if (AW > 1) begin : g_half
      assign buf_in_addr_o  = split_i ? {1'b1, in_addr_i[HW-1:0]}  : in_addr_i;
      assign buf_out_addr_o = split_i ? {1'b0, out_addr_i[HW-1:0]} : out_addr_i;
    end else begin : g_one
      assign buf_in_addr_o  = split_i ? 1'b1 : in_addr_i;
      assign buf_out_addr_o = split_i ? 1'b0 : out_addr_i;
    end
  endgenerate

  assign in_en_o  = split_i | dir_i;
  assign out_en_o = split_i | ~dir_i;
endmodule

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_we_i,
  input  logic [2:0]       cpu_addr_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  input  logic             out_done_i,
  input  logic [CNT_W-1:0] out_len_i,
  output logic             out_nak_o,
  output logic             irq_o,
  input  logic             in_sent_i,
  input  logic             ack_i,
  output logic             toggle_o,
  input  logic [AW-1:0]    in_addr_i,
  input  logic [AW-1:0]    out_addr_i,
  output logic [AW-1:0]    buf_in_addr_o,
  output logic [AW-1:0]    buf_out_addr_o,
  output logic             in_en_o,
  output logic             out_en_o
);
  localparam int HI_W = CNT_W - 8;

  ep_cfg_t          cfg_q;
  logic             wr_stat, wr_ctrl;
  logic             rdy, flag;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       cnt_hi;

  assign wr_stat = cpu_we_i && (cpu_addr_i == REG_STAT);
  assign wr_ctrl = cpu_we_i && (cpu_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_ctrl) cfg_q <= byte_to_cfg(cpu_wdata_i);
  end

  usb_ep_out #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pkt_done_i (out_done_i),
    .pkt_len_i  (out_len_i),
    .clr_rdy_i  (wr_stat & ~cpu_wdata_i[ST_RDY]),
    .clr_flag_i (wr_stat & cpu_wdata_i[ST_FLAG]),
    .rdy_o      (rdy),
    .flag_o     (flag),
    .cnt_o      (cnt),
    .irq_o      (irq_o),
    .nak_o      (out_nak_o)
  );

  usb_ep_toggle u_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sent_i  (in_sent_i),
    .ack_i   (ack_i),
    .force_i (cfg_q.ftog),
    .tog_o   (toggle_o)
  );

  usb_ep_bufmap #(.AW(AW)) u_map (
    .split_i        (cfg_q.split),
    .dir_i          (cfg_q.dir),
    .in_addr_i      (in_addr_i),
    .out_addr_i     (out_addr_i),
    .buf_in_addr_o  (buf_in_addr_o),
    .buf_out_addr_o (buf_out_addr_o),
    .in_en_o        (in_en_o),
    .out_en_o       (out_en_o)
  );

  always_comb begin
    cnt_hi = '0;
    cnt_hi[HI_W-1:0] = cnt[CNT_W-1:8];
  end

  always_comb begin
    cpu_rdata_o = '0;
    unique case (cpu_addr_i)
      REG_STAT: begin
        cpu_rdata_o[ST_RDY]  = rdy;
        cpu_rdata_o[ST_FLAG] = flag;
      end
      REG_CTRL:   cpu_rdata_o = cfg_to_byte(cfg_q);
      REG_CNT_LO: cpu_rdata_o = cnt[7:0];
      REG_CNT_HI: cpu_rdata_o = cnt_hi;
      default:    cpu_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_ctrl_chk.sv
module usb_ep_ctrl_chk #(
  parameter int CNT_W = 10,
  parameter int AW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             out_done_i,
  input logic             out_nak_o,
  input logic             irq_o,
  input logic             in_sent_i,
  input logic             ack_i,
  input logic             toggle_o,
  input logic             rdy,
  input logic [CNT_W-1:0] cnt,
  input logic             ftog,
  input logic             split,
  input logic [AW-1:0]    buf_in_addr_o,
  input logic [AW-1:0]    buf_out_addr_o,
  input logic             in_en_o,
  input logic             out_en_o
);
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_i && !rdy |=> rdy && irq_o);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r5_refuse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_i && rdy |-> out_nak_o);

  a_r5_count_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_i && rdy |=> $stable(cnt) && !irq_o);

  a_r4_no_soft_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy && !out_done_i |=> !rdy);

  a_r8_hold_without_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ftog && !ack_i |=> $stable(toggle_o));

  a_r9_force_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftog && in_sent_i |=> toggle_o != $past(toggle_o));

  a_r9_force_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftog && !in_sent_i |=> $stable(toggle_o));

  a_r10_split_halves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    split |-> in_en_o && out_en_o && buf_in_addr_o[AW-1] && !buf_out_addr_o[AW-1]);

  a_r11_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !split |-> in_en_o != out_en_o);
endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .out_done_i     (out_done_i),
  .out_nak_o      (out_nak_o),
  .irq_o          (irq_o),
  .in_sent_i      (in_sent_i),
  .ack_i          (ack_i),
  .toggle_o       (toggle_o),
  .rdy            (rdy),
  .cnt            (cnt),
  .ftog           (cfg_q.ftog),
  .split          (cfg_q.split),
  .buf_in_addr_o  (buf_in_addr_o),
  .buf_out_addr_o (buf_out_addr_o),
  .in_en_o        (in_en_o),
  .out_en_o       (out_en_o)
);

// File: tb/usb_ep_ctrl_bench.sv
module usb_ep_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;
  localparam int AW = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cpu_we = 1'b0;
  logic [2:0]       cpu_addr = 3'd0;
  logic [7:0]       cpu_wdata = 8'd0;
  logic [7:0]       cpu_rdata;
  logic             out_done = 1'b0;
  logic [CNT_W-1:0] out_len = '0;
  logic             out_nak, irq;
  logic             in_sent = 1'b0;
  logic             ack = 1'b0;
  logic             tog;
  logic [AW-1:0]    in_addr = '0;
  logic [AW-1:0]    out_addr = '0;
  logic [AW-1:0]    b_in, b_out;
  logic             in_en, out_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ep_ctrl #(.CNT_W(CNT_W), .AW(AW)) u_usb_ep_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata),
    .out_done_i(out_done), .out_len_i(out_len), .out_nak_o(out_nak), .irq_o(irq),
    .in_sent_i(in_sent), .ack_i(ack), .toggle_o(tog),
    .in_addr_i(in_addr), .out_addr_i(out_addr),
    .buf_in_addr_o(b_in), .buf_out_addr_o(b_out), .in_en_o(in_en), .out_en_o(out_en)
  );

  // reference model state
  bit m_rdy, m_flag, m_irq, m_tog, m_wait;
  int m_cnt;
  int m_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 0; m_flag = 0; m_irq = 0; m_tog = 0; m_wait = 0; m_cnt = 0; m_ctrl = 0;
    end else begin
      bit took;
      bit ftog;
      took = out_done && !m_rdy;
      ftog = (m_ctrl & 8) != 0;
      m_irq = took;
      if (took) begin
        m_rdy = 1; m_flag = 1; m_cnt = int'(out_len);
      end else if (cpu_we && cpu_addr == 0) begin
        if (!cpu_wdata[0]) m_rdy = 0;
        if (cpu_wdata[1]) m_flag = 0;
      end
      if (took && cpu_we && cpu_addr == 0 && !cpu_wdata[0]) m_rdy = 1;
      if (ftog) begin
        if (in_sent) m_tog = !m_tog;
        m_wait = 0;
      end else begin
        if (ack && m_wait) begin m_tog = !m_tog; m_wait = 0; end
        if (in_sent) m_wait = 1;
      end
      if (cpu_we && cpu_addr == 1) m_ctrl = int'(cpu_wdata) & 8'hEC;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int exp_rd;
      bit sp, dr;
      sp = (m_ctrl & 4) != 0;
      dr = (m_ctrl & 32) != 0;
      case (cpu_addr)
        3'd0: exp_rd = (int'(m_flag) << 1) | int'(m_rdy);
        3'd1: exp_rd = m_ctrl;
        3'd2: exp_rd = m_cnt % 256;
        3'd3: exp_rd = m_cnt / 256;
        default: exp_rd = 0;
      endcase
      case (cpu_addr)
        3'd0: chk("R4 status", int'(cpu_rdata), exp_rd);
        3'd1: chk("R7 ctrl", int'(cpu_rdata), exp_rd);
        default: chk("R3 count", int'(cpu_rdata), exp_rd);
      endcase
      chk("R2 irq", int'(irq), int'(m_irq));
      chk("R5 nak", int'(out_nak), int'(out_done && m_rdy));
      chk((m_ctrl & 8) != 0 ? "R9 toggle" : "R8 toggle", int'(tog), int'(m_tog));
      if (sp) begin
        chk("R10 in addr", int'(b_in), int'(in_addr) % 32 + 32);
        chk("R10 out addr", int'(b_out), int'(out_addr) % 32);
        chk("R10 enables", int'({in_en, out_en}), 3);
      end else begin
        chk("R11 in addr", int'(b_in), int'(in_addr));
        chk("R11 out addr", int'(b_out), int'(out_addr));
        chk("R11 enables", int'({in_en, out_en}), dr ? 2 : 1);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    cpu_we = 0; out_done = 0; in_sent = 0; ack = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    tick();
  endtask

  task automatic pkt(input int len);
    out_done = 1; out_len = CNT_W'(len);
    tick();
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    cpu_addr = a;
    #2;
    chk(tag, int'(cpu_rdata), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3 + 1);
    rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    rd(3'd0, 0, "R1 status after reset");
    rd(3'd1, 0, "R1 ctrl after reset");
    rd(3'd2, 0, "R1 count lo after reset");
    rd(3'd3, 0, "R1 count hi after reset");
    chk("R1 toggle after reset", int'(tog), 0);
    chk("R1 irq after reset", int'(irq), 0);

    // R2 accept, irq pulse one cycle later
    out_done = 1; out_len = 10'd300;
    @(posedge clk); #1; out_done = 0;
    chk("R2 irq pulse", int'(irq), 1);
    rd(3'd0, 3, "R2 status after packet");
    tick();
    chk("R2 irq single cycle", int'(irq), 0);
    rd(3'd2, 44, "R3 count low byte");
    rd(3'd3, 1, "R3 count high byte");

    // R5 refuse while held
    out_done = 1; out_len = 10'd5; #2;
    chk("R5 nak same cycle", int'(out_nak), 1);
    tick();
    rd(3'd2, 44, "R5 count unchanged");
    chk("R5 no irq", int'(irq), 0);

    // R4 write 1 does nothing; R6 flag clear alone
    wr(3'd0, 8'h01);
    rd(3'd0, 3, "R4 write one keeps ready");
    wr(3'd0, 8'h03);
    rd(3'd0, 1, "R6 flag cleared ready kept");
    wr(3'd0, 8'h00);
    rd(3'd0, 0, "R4 ready released");
    wr(3'd0, 8'h01);
    rd(3'd0, 0, "R4 write one cannot set");

    // R6 collision: accept with flag clear
    cpu_we = 1; cpu_addr = 3'd0; cpu_wdata = 8'h03;
    out_done = 1; out_len = 10'd7;
    tick();
    rd(3'd0, 3, "R6 set beats clear");
    rd(3'd2, 7, "R6 count taken");

    // R5 collision: refuse while firmware releases
    cpu_we = 1; cpu_addr = 3'd0; cpu_wdata = 8'h02;
    out_done = 1; out_len = 10'd99; #2;
    chk("R5 nak during release", int'(out_nak), 1);
    tick();
    rd(3'd0, 0, "R5 released after collision");
    rd(3'd2, 7, "R5 count kept after collision");

    // R7 control bits
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'hEC, "R7 unused bits read zero");
    wr(3'd1, 8'h13);
    rd(3'd1, 0, "R7 only unused bits written");

    // R8 normal toggle
    wr(3'd1, 8'h00);
    ack = 1; tick();
    chk("R8 lone ack ignored", int'(tog), 0);
    in_sent = 1; tick();
    chk("R8 no ack yet", int'(tog), 0);
    ack = 1; tick();
    chk("R8 ack flips", int'(tog), 1);
    ack = 1; tick();
    chk("R8 second ack ignored", int'(tog), 1);

    // R9 forced toggle
    wr(3'd1, 8'h08);
    for (int i = 0; i < 3; i++) begin
      in_sent = 1; tick();
      chk("R9 flip per send", int'(tog), (i % 2 == 0) ? 0 : 1);
    end
    ack = 1; tick();
    chk("R9 ack ignored", int'(tog), 0);

    // R10 / R11 buffer mapping
    in_addr = 6'h05; out_addr = 6'h3A;
    wr(3'd1, 8'h24);
    rd(3'd1, 8'h24, "R10 ctrl split dir in");
    chk("R10 in upper", int'(b_in), 6'h25);
    chk("R10 out lower", int'(b_out), 6'h1A);
    wr(3'd1, 8'h04);
    chk("R10 dir ignored", int'({in_en, out_en}), 3);
    wr(3'd1, 8'h20);
    chk("R11 in owns", int'({in_en, out_en}), 2);
    chk("R11 passthrough", int'(b_out), 6'h3A);
    wr(3'd1, 8'h00);
    chk("R11 out owns", int'({in_en, out_en}), 1);

    repeat (3) tick();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule